// File: doc/BRIEF.md
# Galois XNOR Pseudo-Random Sequence Generator with Spin

This block produces a pseudo-random state sequence from a Galois-form linear feedback shift register. Its width is chosen at elaboration from 3 to 15 bits, and each width takes its feedback mask from a built-in table. The feedback gates are XNOR, so the all-zeroes state is an ordinary member of the sequence. The all-ones state is the only lockup point, and the block never enters it. Each next state is a shift combined with a mask toggle, so it settles in one shallow level of logic.

A spin input makes each request advance the register by several single steps within one clock. The same state set is then visited in a different order, which lets a test harness draw distinct address streams from one register size. A seed can be loaded at any time. A seed of all-ones is replaced by all-zeroes, and a one-cycle error flag reports the replacement.

Top module: `prs_galois_xnor`

## Requirements
- R1: While reset is high and on the first cycle after it, `state_o` is 0, and `valid_o` and `seed_err_o` are both low.
- R2: With a spin of 1 in the 3-bit configuration, starting from 0, successive requests give 2, 3, 5, 6, 1, 4, 0 and then repeat with a period of 7. The new value appears in the cycle after the request.
- R3: With a spin value s between 1 and MAX_SPIN, each request moves the state s places along the single-step sequence. In the 3-bit configuration with spin 2, starting from 0, the sequence is 3, 6, 4, 2, 5, 1, 0.
- R4: A spin value of 0 behaves exactly like a spin value of 1.
- R5: For every width from 3 to 15, single stepping from 0 first returns to 0 after exactly 2^WIDTH − 1 requests, and the all-ones state is never reached.
- R6: A load with a seed other than all-ones places that seed in `state_o` on the next cycle with `seed_err_o` low. A load of all-ones places 0 in `state_o` and raises `seed_err_o` for that cycle only.
- R7: In a cycle with neither load nor request, the state does not change, and `valid_o` is low in the following cycle.
- R8: `valid_o` is high for exactly the cycle after any cycle that has a load or a request.
- R9: When load and request are high in the same cycle, the loaded seed wins and the state is not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load `seed_i` into the register |
| seed_i | input | WIDTH | Seed value |
| next_i | input | 1 | Request the next value |
| spin_i | input | $clog2(MAX_SPIN+1) | Single steps per request (0 is taken as 1) |
| state_o | output | WIDTH | Current register state |
| valid_o | output | 1 | A fresh value was produced in the previous cycle |
| seed_err_o | output | 1 | The previous load carried the lockup value and was replaced |

## Verification
The assertions check the properties that hold on every cycle: the register never holds all-ones, the state is unchanged when no load or request is present, valid follows load or request, load takes priority, and a lockup seed is replaced with a single error pulse. The exact order of the sequence for each spin value, the equivalence of spin 0 and spin 1, and the full period of every width from 3 to 15 can only be shown by the bench's scenarios. The bench drives a 3-bit instance through every spin value, and it steps one instance of each larger width through 32767 requests, comparing each against its own reference model.

// File: rtl/prs_lfsr_pkg.sv
package prs_lfsr_pkg;

   localparam int MIN_WIDTH = 3;
   localparam int MAX_WIDTH = 15;

   // Toggle mask for a right-shifting Galois register. Bit k-1 is set for
   // every middle term x^k of a primitive polynomial of degree WIDTH.
   function automatic logic [MAX_WIDTH-1:0] toggle_mask(input int width);
      logic [MAX_WIDTH-1:0] m;
      case (width)
         3:       m = 15'h0002;
         4:       m = 15'h0004;
         5:       m = 15'h0004;
         6:       m = 15'h0010;
         7:       m = 15'h0020;
         8:       m = 15'h0038;
         9:       m = 15'h0010;
         10:      m = 15'h0040;
         11:      m = 15'h0100;
         12:      m = 15'h0608;
         13:      m = 15'h0C80;
         14:      m = 15'h1802;
         15:      m = 15'h2000;
         default: m = 15'h0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/prs_lfsr_step.sv
module prs_lfsr_step #(
   parameter int                 WIDTH = 8,
   parameter logic [WIDTH-1:0]   TAPS  = '0
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);

   logic             out_bit;
   logic [WIDTH-1:0] shifted;

   always_comb begin
      out_bit = cur_i[0];
      shifted = {out_bit, cur_i[WIDTH-1:1]};
      // XNOR at tap positions: the tap bit toggles when the output bit is 0
      nxt_o   = shifted ^ (TAPS & {WIDTH{~out_bit}});
   end

   // R5: a legal state never steps into the lockup state
   always_comb begin
      a_no_lockup_entry_r5: assert (cur_i == '1 || nxt_o != '1)
         else $error("step entered the lockup state");
   end

endmodule

// File: rtl/prs_spin_chain.sv
module prs_spin_chain #(
   parameter int               WIDTH    = 8,
   parameter int               MAX_SPIN = 15,
   parameter logic [WIDTH-1:0] TAPS     = '0,
   localparam int              SPIN_W   = $clog2(MAX_SPIN + 1)
) (
   input  logic [WIDTH-1:0]  cur_i,
   input  logic [SPIN_W-1:0] spin_i,
   output logic [WIDTH-1:0]  adv_o
);

   logic [WIDTH-1:0] stage [MAX_SPIN+1];
   int               eff_spin;

   assign stage[0] = cur_i;

   for (genvar k = 0; k < MAX_SPIN; k++) begin : g_stage
      prs_lfsr_step #(
         .WIDTH (WIDTH),
         .TAPS  (TAPS)
      ) u_step (
         .cur_i (stage[k]),
         .nxt_o (stage[k+1])
      );
   end

   always_comb begin
      if (spin_i == '0)
         eff_spin = 1;
      else if (int'(spin_i) > MAX_SPIN)
         eff_spin = MAX_SPIN;
      else
         eff_spin = int'(spin_i);
   end

   always_comb begin
      adv_o = stage[1];
      for (int k = 2; k <= MAX_SPIN; k++) begin
         if (k == eff_spin) adv_o = stage[k];
      end
   end

endmodule

// File: rtl/prs_seed_guard.sv
module prs_seed_guard #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] safe_o,
   output logic             locked_o
);

   always_comb begin
      locked_o = &seed_i;
      safe_o   = locked_o ? '0 : seed_i;
   end

endmodule

// File: rtl/prs_galois_xnor.sv
module prs_galois_xnor #(
   parameter int  WIDTH    = 8,
   parameter int  MAX_SPIN = 15,
   localparam int SPIN_W   = $clog2(MAX_SPIN + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [WIDTH-1:0]  seed_i,
   input  logic              next_i,
   input  logic [SPIN_W-1:0] spin_i,
   output logic [WIDTH-1:0]  state_o,
   output logic              valid_o,
   output logic              seed_err_o
);

   import prs_lfsr_pkg::*;

   localparam logic [MAX_WIDTH-1:0] FULL_MASK = toggle_mask(WIDTH);
   localparam logic [WIDTH-1:0]     TAPS      = FULL_MASK[WIDTH-1:0];

   if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("WIDTH must lie between 3 and 15");
   end
   if (MAX_SPIN < 1) begin : g_bad_spin
      $error("MAX_SPIN must be at least 1");
   end

   logic [WIDTH-1:0] state_q;
   logic             valid_q;
   logic             err_q;
   logic [WIDTH-1:0] adv;
   logic [WIDTH-1:0] safe_seed;
   logic             seed_locked;

   prs_spin_chain #(
      .WIDTH    (WIDTH),
      .MAX_SPIN (MAX_SPIN),
      .TAPS     (TAPS)
   ) u_chain (
      .cur_i  (state_q),
      .spin_i (spin_i),
      .adv_o  (adv)
   );

   prs_seed_guard #(
      .WIDTH (WIDTH)
   ) u_guard (
      .seed_i   (seed_i),
      .safe_o   (safe_seed),
      .locked_o (seed_locked)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= '0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         valid_q <= load_i | next_i;
         err_q   <= load_i & seed_locked;
         if (load_i)
            state_q <= safe_seed;
         else if (next_i)
            state_q <= adv;
      end
   end

   assign state_o    = state_q;
   assign valid_o    = valid_q;
   assign seed_err_o = err_q;

   p_lockup_never_r5: assert property (@(posedge clk) disable iff (rst)
      state_q != '1);

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !next_i) |=> ($stable(state_o) && !valid_o));

   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      (load_i || next_i) |=> valid_o);

   p_seed_reject_r6: assert property (@(posedge clk) disable iff (rst)
      (load_i && (&seed_i)) |=> (seed_err_o && state_o == '0));

   p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
      !(load_i && (&seed_i)) |=> !seed_err_o);

   p_load_priority_r9: assert property (@(posedge clk) disable iff (rst)
      (load_i && !(&seed_i)) |=> (state_o == $past(seed_i)));

endmodule

// File: tb/prs_galois_xnor_tb.sv
`timescale 1ns/1ps
module prs_galois_xnor_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic [2:0] seed = '0;
   logic       nxt = 1'b0;
   logic [3:0] spin = 4'd1;
   logic [2:0] st;
   logic       vld;
   logic       err;

   logic       sw_next = 1'b0;
   logic       sw_on = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   int first_ret [16];
   bit saw_lock  [16];
   bit mism      [16];

   always #4 clk = ~clk;   // 125 MHz

   prs_galois_xnor #(.WIDTH(3), .MAX_SPIN(15)) u_dut (
      .clk(clk), .rst(rst), .load_i(load), .seed_i(seed), .next_i(nxt),
      .spin_i(spin), .state_o(st), .valid_o(vld), .seed_err_o(err)
   );

   // Independent reference: bench-side mask table, right shift, XNOR taps
   function automatic int ref_mask(int w);
      case (w)
         3: return 'h2;    4: return 'h4;    5: return 'h4;
         6: return 'h10;   7: return 'h20;   8: return 'h38;
         9: return 'h10;   10: return 'h40;  11: return 'h100;
         12: return 'h608; 13: return 'hC80; 14: return 'h1802;
         15: return 'h2000;
         default: return 0;
      endcase
   endfunction

   function automatic int ref_next(int w, int x);
      int b = x & 1;
      int n = (x >> 1) | (b << (w - 1));
      if (b == 0) n = n ^ ref_mask(w);
      return n;
   endfunction

   for (genvar w = 4; w <= 15; w++) begin : g_w
      logic [w-1:0] sst;
      logic         svld;
      logic         serr;
      int           cnt = 0;
      int           model = 0;

      prs_galois_xnor #(.WIDTH(w), .MAX_SPIN(15)) u_sweep (
         .clk(clk), .rst(rst), .load_i(1'b0), .seed_i('0), .next_i(sw_next),
         .spin_i(4'd1), .state_o(sst), .valid_o(svld), .seed_err_o(serr)
      );

      initial begin
         first_ret[w] = 0;
         saw_lock[w]  = 1'b0;
         mism[w]      = 1'b0;
      end

      always @(posedge clk) begin
         #2;
         if (sw_on) begin
            cnt++;
            model = ref_next(w, model);
            if (int'(sst) != model) mism[w] = 1'b1;
            if (&sst) saw_lock[w] = 1'b1;
            if (sst == '0 && first_ret[w] == 0) first_ret[w] = cnt;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(bit ld, logic [2:0] sd, bit nx, logic [3:0] sp);
      @(negedge clk);
      load = ld; seed = sd; nxt = nx; spin = sp;
      @(posedge clk);
      #1;
   endtask

   int seq3 [7] = '{0, 2, 3, 5, 6, 1, 4};

   initial begin
      int idx;
      int es;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 state in reset", int'(st), 0);
      chk("R1 valid in reset", int'(vld), 0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 state after reset", int'(st), 0);
      chk("R1 err after reset", int'(err), 0);
      chk("R1 valid after reset", int'(vld), 0);

      // R2: single step, two full periods
      idx = 0;
      for (int i = 0; i < 14; i++) begin
         drive(0, 3'd0, 1, 4'd1);
         idx = (idx + 1) % 7;
         chk("R2 single-step sequence", int'(st), seq3[idx]);
         chk("R8 valid after request", int'(vld), 1);
      end

      // R4: spin 0 behaves as spin 1
      for (int i = 0; i < 7; i++) begin
         drive(0, 3'd0, 1, 4'd0);
         idx = (idx + 1) % 7;
         chk("R4 spin zero as one", int'(st), seq3[idx]);
      end

      // R3: spin 2 from 0
      drive(1, 3'd0, 0, 4'd2);
      chk("R6 load zero", int'(st), 0);
      idx = 0;
      for (int i = 0; i < 7; i++) begin
         drive(0, 3'd0, 1, 4'd2);
         idx = (idx + 2) % 7;
         chk("R3 spin two sequence", int'(st), seq3[idx]);
      end

      // R3: every spin value, three requests each
      for (int s = 0; s < 16; s++) begin
         es = (s == 0) ? 1 : s;
         for (int i = 0; i < 3; i++) begin
            drive(0, 3'd0, 1, 4'(s));
            idx = (idx + es) % 7;
            chk("R3 spin sweep", int'(st), seq3[idx]);
         end
      end

      // R7: hold without load or request
      es = int'(st);
      for (int i = 0; i < 4; i++) begin
         drive(0, 3'd0, 0, 4'd3);
         chk("R7 state held", int'(st), es);
         chk("R7 valid low when idle", int'(vld), 0);
      end

      // R6: legal seed
      drive(1, 3'd5, 0, 4'd1);
      chk("R6 legal seed loaded", int'(st), 5);
      chk("R6 no error on legal seed", int'(err), 0);
      chk("R8 valid after load", int'(vld), 1);
      drive(0, 3'd0, 1, 4'd1);
      chk("R2 step from loaded seed", int'(st), 6);

      // R6: lockup seed replaced
      drive(1, 3'd7, 0, 4'd1);
      chk("R6 lockup seed replaced", int'(st), 0);
      chk("R6 error pulse", int'(err), 1);
      drive(0, 3'd0, 0, 4'd1);
      chk("R6 error lasts one cycle", int'(err), 0);
      chk("R7 state held after reject", int'(st), 0);

      // R9: load wins over request
      drive(1, 3'd6, 1, 4'd1);
      chk("R9 load priority", int'(st), 6);
      drive(0, 3'd0, 1, 4'd1);
      chk("R9 step after priority load", int'(st), 1);
      drive(0, 3'd0, 0, 4'd1);

      // R5: full period sweep of widths 4..15
      @(negedge clk);
      sw_next = 1'b1;
      sw_on   = 1'b1;
      repeat (32767) @(posedge clk);
      @(negedge clk);
      sw_next = 1'b0;
      sw_on   = 1'b0;
      repeat (2) @(posedge clk);
      for (int w = 4; w <= 15; w++) begin
         chk($sformatf("R5 period width %0d", w), first_ret[w], (1 << w) - 1);
         chk($sformatf("R5 lockup never width %0d", w), int'(saw_lock[w]), 0);
         chk($sformatf("R5 reference match width %0d", w), int'(mism[w]), 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 190000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule